// File: doc/BRIEF.md
# MII Manchester Transmit Serializer

This block turns 4-bit MII transmit nibbles into a serial Manchester half-bit stream for a 10 Mb/s twisted-pair line driver. Everything runs on a single 100 MHz reference clock. A divide-by-five counter gives a 20 MHz half-bit strobe. Counting that strobe gives the 2.5 MHz nibble clock `tx_clk`, which the block drives back to the MAC.

On each rising edge of `tx_clk` the block samples `txd`, `tx_en` and `tx_er`. An enabled nibble becomes eight half-bit symbols, sent least significant bit first, one symbol per strobe. A nibble flagged as an error becomes a fixed code-violation pattern. The first two bits of every frame are not driven. After `tx_en` drops, the line returns to idle once the last full nibble has been sent. When `mode_en` is low the block stays silent and holds its clock low.

The symbol output `tx_sym` comes with a drive qualifier `tx_act`. The analog pulse shaper uses `tx_act` to decide whether to drive the line at all.

Top module: `mii_manchester_tx`

## Requirements
- R1: `tx_clk` has a period of 40 reference cycles (2 x NIB_W half-bits of REF_DIV cycles each). It is high for 20 cycles and low for 20 cycles.
- R2: `txd`, `tx_en` and `tx_er` are sampled at the reference edge where `tx_clk` rises. A nibble is sent only if `tx_en` was high at that edge.
- R3: Bits of a nibble go out least significant first. Each bit takes two half-bit symbols: a 1 is sent as `tx_sym` 0 then 1, and a 0 is sent as 1 then 0. `tx_act` is 1 for every driven symbol.
- R4: The first half-bit of a sampled nibble appears REF_DIV reference cycles (50 ns) after the sampling edge. Each half-bit is then held for REF_DIV cycles, so the eight half-bits fill the following 40 cycles.
- R5: If `tx_er` and `tx_en` are both high at the sampling edge, the eight half-bits are 0,0,1,1,0,0,1,1 in place of the data.
- R6: A frame starts with a nibble sampled with `tx_en` high whose previous sample had `tx_en` low, or which is the first sample after reset or re-enable. For that nibble, the first four half-bits (two bits) are output with `tx_act`=0 and `tx_sym`=0.
- R7: A nibble sampled with `tx_en` low produces `tx_act`=0 and `tx_sym`=0 for all eight half-bits, whatever `tx_er` and `txd` are. The nibble before it is still sent in full. `tx_sym` is 0 whenever `tx_act` is 0.
- R8: While `mode_en` is low, `tx_clk`, `tx_act` and `tx_sym` are all 0 from the next reference cycle on. After re-enable, the first nibble of the next frame is treated as a frame start.
- R9: During and right after reset, `tx_clk`, `tx_act` and `tx_sym` are 0. They stay idle until the first sampled nibble appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Selects 10 Mb/s operation; low holds the block idle |
| txd | input | NIB_W | Transmit nibble from the MAC |
| tx_en | input | 1 | Nibble valid from the MAC |
| tx_er | input | 1 | Error flag from the MAC; forces the violation pattern |
| tx_clk | output | 1 | Generated 2.5 MHz nibble clock |
| tx_act | output | 1 | High while the line is being driven |
| tx_sym | output | 1 | Current Manchester half-bit symbol |

## Verification
The timing assertions assume that `mode_en` does not change while a period measurement is in progress. They discard their history whenever `mode_en` is low, because a re-enable restarts `tx_clk` at an arbitrary point. The stimulus changes `txd`, `tx_en` and `tx_er` only on falling edges of `tx_clk`, so the inputs are stable at every sampling edge. It drops `mode_en` only on reference-clock edges and keeps it low long enough that the restart is observed as a fresh frame. Input patterns cover all sixteen nibble values, error nibbles at the start and middle of a frame, an error flag without enable, and a disable in the middle of a frame.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  localparam int unsigned NIB_W_DEF     = 4;
  localparam int unsigned REF_DIV_DEF   = 5;
  localparam int unsigned SKIP_BITS_DEF = 2;

  // Level of the code-violation pattern at a given half-bit slot: 0,0,1,1 repeating.
  function automatic logic jk_level(input int unsigned hb);
    return ((hb >> 1) & 1) != 0;
  endfunction

endpackage

// File: rtl/mtx_halfbit_tick.sv
module mtx_halfbit_tick #(
  parameter int unsigned REF_DIV = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic hb_stb
);
  localparam int unsigned CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hb_stb = run && (cnt_q == LAST);

endmodule

// File: rtl/mtx_txclk_gen.sv
module mtx_txclk_gen #(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned HB   = 2 * NIB_W,
  localparam int unsigned IW   = $clog2(HB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          hb_stb,
  output logic          tx_clk,
  output logic          cap_stb,
  output logic [IW-1:0] hb_idx
);
  localparam logic [IW-1:0] LAST_HB = IW'(HB - 1);
  localparam logic [IW-1:0] FALL_HB = IW'(NIB_W - 1);
  localparam logic [IW-1:0] START   = IW'(NIB_W);

  logic [IW-1:0] hcnt_q;
  logic          clk_q;

  // Start in the low phase so the first rising edge is a sampling edge.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hcnt_q <= START;
      clk_q  <= 1'b0;
    end else if (hb_stb) begin
      if (hcnt_q == LAST_HB) begin
        hcnt_q <= '0;
        clk_q  <= 1'b1;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
        if (hcnt_q == FALL_HB) begin
          clk_q <= 1'b0;
        end
      end
    end
  end

  assign tx_clk  = clk_q;
  assign cap_stb = hb_stb && (hcnt_q == LAST_HB);
  assign hb_idx  = hcnt_q;

endmodule

// File: rtl/mtx_nibble_encoder.sv
module mtx_nibble_encoder
  import mtx_pkg::*;
#(
  parameter int unsigned NIB_W     = 4,
  parameter int unsigned SKIP_BITS = 2,
  localparam int unsigned HB       = 2 * NIB_W
) (
  input  logic [NIB_W-1:0] nib,
  input  logic             en,
  input  logic             er,
  input  logic             first,
  output logic [HB-1:0]    sym,
  output logic [HB-1:0]    act
);
  logic [HB-1:0] dat_sym;

  for (genvar i = 0; i < NIB_W; i++) begin : g_bit
    assign dat_sym[2*i]   = ~nib[i];
    assign dat_sym[2*i+1] =  nib[i];
  end

  for (genvar j = 0; j < HB; j++) begin : g_hb
    if (j < 2 * SKIP_BITS) begin : g_skip
      assign act[j] = en & ~first;
    end else begin : g_keep
      assign act[j] = en;
    end
    assign sym[j] = act[j] & (er ? jk_level(j) : dat_sym[j]);
  end

endmodule

// File: rtl/mtx_serializer.sv
module mtx_serializer #(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned HB   = 2 * NIB_W,
  localparam int unsigned IW   = $clog2(HB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          hb_stb,
  input  logic          cap_stb,
  input  logic [IW-1:0] hb_idx,
  input  logic          en,
  input  logic [HB-1:0] enc_sym,
  input  logic [HB-1:0] enc_act,
  output logic          first,
  output logic          tx_act,
  output logic          tx_sym
);
  logic [HB-1:0] buf_sym_q;
  logic [HB-1:0] buf_act_q;
  logic          in_frame_q;
  logic          act_q;
  logic          sym_q;

  // The slot leaving at a sampling edge is the old nibble's last half-bit,
  // so one buffer covers both the outgoing and the incoming nibble.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      buf_sym_q  <= '0;
      buf_act_q  <= '0;
      in_frame_q <= 1'b0;
      act_q      <= 1'b0;
      sym_q      <= 1'b0;
    end else if (hb_stb) begin
      act_q <= buf_act_q[hb_idx];
      sym_q <= buf_sym_q[hb_idx];
      if (cap_stb) begin
        buf_sym_q  <= enc_sym;
        buf_act_q  <= enc_act;
        in_frame_q <= en;
      end
    end
  end

  assign first  = en & ~in_frame_q;
  assign tx_act = act_q;
  assign tx_sym = sym_q;

endmodule

// File: rtl/mii_manchester_tx.sv
module mii_manchester_tx
  import mtx_pkg::*;
#(
  parameter int unsigned NIB_W     = NIB_W_DEF,
  parameter int unsigned REF_DIV   = REF_DIV_DEF,
  parameter int unsigned SKIP_BITS = SKIP_BITS_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_en,
  input  logic [NIB_W-1:0] txd,
  input  logic             tx_en,
  input  logic             tx_er,
  output logic             tx_clk,
  output logic             tx_act,
  output logic             tx_sym
);
  localparam int unsigned HB = 2 * NIB_W;
  localparam int unsigned IW = $clog2(HB);

  logic          hb_stb;
  logic          cap_stb;
  logic [IW-1:0] hb_idx;
  logic          first;
  logic [HB-1:0] enc_sym;
  logic [HB-1:0] enc_act;

  mtx_halfbit_tick #(.REF_DIV(REF_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run    (mode_en),
    .hb_stb (hb_stb)
  );

  mtx_txclk_gen #(.NIB_W(NIB_W)) u_clkgen (
    .clk     (clk),
    .rst     (rst),
    .run     (mode_en),
    .hb_stb  (hb_stb),
    .tx_clk  (tx_clk),
    .cap_stb (cap_stb),
    .hb_idx  (hb_idx)
  );

  mtx_nibble_encoder #(.NIB_W(NIB_W), .SKIP_BITS(SKIP_BITS)) u_enc (
    .nib   (txd),
    .en    (tx_en),
    .er    (tx_er),
    .first (first),
    .sym   (enc_sym),
    .act   (enc_act)
  );

  mtx_serializer #(.NIB_W(NIB_W)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .run     (mode_en),
    .hb_stb  (hb_stb),
    .cap_stb (cap_stb),
    .hb_idx  (hb_idx),
    .en      (tx_en),
    .enc_sym (enc_sym),
    .enc_act (enc_act),
    .first   (first),
    .tx_act  (tx_act),
    .tx_sym  (tx_sym)
  );

endmodule

// File: rtl/mtx_tx_checker.sv
module mtx_tx_checker #(
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned REF_DIV = 5
) (
  input logic clk,
  input logic rst,
  input logic mode_en,
  input logic tx_clk,
  input logic tx_act,
  input logic tx_sym
);
  localparam int unsigned PER = 2 * NIB_W * REF_DIV;
  localparam int unsigned CW  = $clog2(PER) + 2;
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  logic [CW-1:0] cyc;
  logic          seen;
  logic          clk_d;
  logic          act_d;
  logic          sym_d;

  always_ff @(posedge clk) begin
    if (rst || !mode_en) begin
      cyc   <= '0;
      seen  <= 1'b0;
      clk_d <= 1'b0;
      act_d <= 1'b0;
      sym_d <= 1'b0;
    end else begin
      clk_d <= tx_clk;
      act_d <= tx_act;
      sym_d <= tx_sym;
      if (tx_clk && !clk_d) begin
        cyc  <= CW'(1);
        seen <= 1'b1;
      end else if (cyc != SAT) begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> (!tx_clk && !tx_act && !tx_sym));

  a_r7_idle_level: assert property (@(posedge clk) disable iff (rst)
    !tx_act |-> !tx_sym);

  a_r1_txclk_period: assert property (@(posedge clk) disable iff (rst || !mode_en)
    (seen && tx_clk && !clk_d) |-> (cyc == CW'(PER)));

  a_r1_txclk_high_time: assert property (@(posedge clk) disable iff (rst || !mode_en)
    (seen && !tx_clk && clk_d) |-> (cyc == CW'(PER / 2)));

  a_r4_halfbit_grid: assert property (@(posedge clk) disable iff (rst || !mode_en)
    (seen && ((tx_act != act_d) || (tx_sym != sym_d))) |-> ((cyc % CW'(REF_DIV)) == '0));

endmodule

bind mii_manchester_tx mtx_tx_checker #(.NIB_W(NIB_W), .REF_DIV(REF_DIV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode_en (mode_en),
  .tx_clk  (tx_clk),
  .tx_act  (tx_act),
  .tx_sym  (tx_sym)
);

// File: tb/tb_mii_manchester_tx.sv
module tb_mii_manchester_tx;
  localparam int NIB_W = 4;
  localparam int REF_DIV = 5;
  localparam int HB = 2 * NIB_W;
  localparam int PER = HB * REF_DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_en = 1'b0;
  logic [NIB_W-1:0] txd = '0;
  logic tx_en = 1'b0;
  logic tx_er = 1'b0;
  logic tx_clk, tx_act, tx_sym;

  always #5 clk = ~clk;

  mii_manchester_tx #(.NIB_W(NIB_W), .REF_DIV(REF_DIV)) dut (
    .clk(clk), .rst(rst), .mode_en(mode_en), .txd(txd), .tx_en(tx_en), .tx_er(tx_er),
    .tx_clk(tx_clk), .tx_act(tx_act), .tx_sym(tx_sym)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected half-bits of one sampled nibble, from R3/R5/R6/R7.
  function automatic void build(input logic [NIB_W-1:0] d, input bit en, input bit er,
                                input bit first, output logic [HB-1:0] s, output logic [HB-1:0] a);
    for (int j = 0; j < HB; j++) begin
      bit b;
      b = d[j/2];
      a[j] = en && !(first && j < 4);
      s[j] = a[j] && (er ? ((j / 2) % 2 == 1) : ((j % 2 == 1) ? b : !b));
    end
  endfunction

  function automatic string tag(input int j, input bit en, input bit er, input bit first);
    if (!en) return "R7 idle nibble";
    if (first && j < 4) return "R6 suppressed start bits";
    if (er) return "R5 violation pattern";
    if (j == 0) return "R4 first half-bit timing";
    return "R3 encoding";
  endfunction

  // Monitor state
  logic [HB-1:0] cur_s, cur_a, prv_s, prv_a;
  bit cur_en, cur_er, cur_first, prv_en, prv_er, prv_first;
  bit started, clk_prev, mode_prev, last_en;
  int cnt;

  always @(negedge clk) begin
    if (rst) begin
      started = 0; clk_prev = 0; last_en = 0; cnt = 0;
      cur_s = '0; cur_a = '0; prv_s = '0; prv_a = '0;
      cur_en = 0; cur_er = 0; cur_first = 0; prv_en = 0; prv_er = 0; prv_first = 0;
    end else if (!mode_en) begin
      if (!mode_prev)
        chk(!tx_clk && !tx_act && !tx_sym, "R8 quiet while disabled",
            int'({tx_clk, tx_act, tx_sym}), 0);
      started = 0; clk_prev = 0; last_en = 0; cnt = 0;
      cur_s = '0; cur_a = '0; prv_s = '0; prv_a = '0;
      cur_en = 0; prv_en = 0;
    end else begin
      cnt++;
      if (tx_clk && !clk_prev) begin
        if (started) chk(cnt == PER, "R1 tx_clk period", cnt, PER);
        prv_s = cur_s; prv_a = cur_a;
        prv_en = cur_en; prv_er = cur_er; prv_first = cur_first;
        cur_en = tx_en; cur_er = tx_er; cur_first = tx_en && !last_en;
        build(txd, tx_en, tx_er, cur_first, cur_s, cur_a);   // R2: sampled at the rise
        last_en = tx_en;
        started = 1;
        cnt = 0;
      end else if (!tx_clk && clk_prev && started) begin
        chk(cnt == PER / 2, "R1 tx_clk high time", cnt, PER / 2);
      end
      if (!started) begin
        chk(!tx_act && !tx_sym, "R9 idle before first sample", int'({tx_act, tx_sym}), 0);
      end else begin
        if (cnt == 2)
          chk({tx_act, tx_sym} == {prv_a[HB-1], prv_s[HB-1]},
              tag(HB - 1, prv_en, prv_er, prv_first),
              int'({tx_act, tx_sym}), int'({prv_a[HB-1], prv_s[HB-1]}));
        for (int j = 0; j < HB - 1; j++) begin
          if (cnt == REF_DIV * j + REF_DIV + 2)
            chk({tx_act, tx_sym} == {cur_a[j], cur_s[j]},
                tag(j, cur_en, cur_er, cur_first),
                int'({tx_act, tx_sym}), int'({cur_a[j], cur_s[j]}));
        end
      end
      clk_prev = tx_clk;
    end
    mode_prev = mode_en;
  end

  task automatic send(input logic [NIB_W-1:0] d, input bit en, input bit er);
    @(negedge tx_clk);
    txd = d; tx_en = en; tx_er = er;
  endtask

  initial begin
    mode_en = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(!tx_clk && !tx_act && !tx_sym, "R9 reset state", int'({tx_clk, tx_act, tx_sym}), 0);
    rst = 1'b0;

    send(4'h0, 0, 0); send(4'h0, 0, 0);
    // R3: sweep of every nibble value in one frame
    for (int v = 0; v < 16; v++) send(4'(v), 1, 0);
    send(4'h0, 0, 0); send(4'h0, 0, 0);
    // R5: error nibble in the middle of a frame
    send(4'h5, 1, 0); send(4'h9, 1, 1); send(4'hA, 1, 0);
    send(4'h0, 0, 0);
    // R5 with R6: error nibble at the frame start
    send(4'h3, 1, 1); send(4'hF, 1, 1); send(4'h6, 1, 0);
    send(4'h0, 0, 0);
    // R7: error flag without enable is ignored
    send(4'h7, 0, 1); send(4'hE, 0, 1);
    // R7: single-nibble frame then idle
    send(4'h3, 1, 0); send(4'h0, 0, 0); send(4'hB, 0, 0);
    // R8: disable in mid-frame
    send(4'h6, 1, 0); send(4'h9, 1, 0);
    repeat (13) @(posedge clk);
    mode_en = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk);
      txd = 4'(k);
      tx_en = 1'b1;
    end
    tx_en = 1'b0;
    @(posedge clk);
    mode_en = 1'b1;
    send(4'h0, 0, 0);
    // R8: restart counts as a new frame start
    send(4'hC, 1, 0); send(4'h1, 1, 0);
    send(4'h0, 0, 0); send(4'h0, 0, 0);
    repeat (60) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule